// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor request port and a word-wide backing memory. It holds four sets of two one-word lines, 32 bytes in all. Every line keeps a valid bit, a dirty bit and a tag, and every set keeps one replacement bit that names the way to evict next. Writes stay in the cache until their line is displaced (write-back), and a write miss first loads the line and then merges the write into it (write-allocate). The processor always gets its data from the cache array: on a miss the word is loaded first and the access then completes as a hit in the cache.

The processor raises `cpu_req` with the address, direction and write data, and keeps them steady until `cpu_ready` pulses for one cycle. In that cycle `cpu_rdata` carries the word, and exactly one of `cpu_hit` or `cpu_miss` reports how the access was served. On the memory side the cache raises `mem_req` with the address, direction and data, holds them, and moves on when `mem_ack` pulses. On a read, `mem_rdata` is valid in the cycle that `mem_ack` is high.

The controller has four states. IDLE waits for a request and latches it (IDLE to LOOKUP). LOOKUP compares both tags. On a hit it answers the processor and returns to IDLE. On a miss it picks a victim and goes to FLUSH if the victim is valid and dirty, otherwise to FILL. FLUSH writes the victim word to memory and goes to FILL on acknowledge. FILL reads the requested word, installs it clean, and goes back to LOOKUP on acknowledge, where the access now hits.

Top module: `cache2w`

## Requirements
- R1: Reset clears every valid, dirty and replacement bit. After reset `cpu_ready` and `mem_req` are low, the first access to any address misses, and no line is ever written back.
- R2: The index is address bits [3:2] and the tag is bits [31:4]; bits [1:0] are ignored. Two addresses with the same index and different tags can be resident at the same time.
- R3: A read miss issues one memory read at the word address (low two bits zero), then answers with `cpu_miss`=1 and the word that memory returned.
- R4: A read hit answers with `cpu_hit`=1 and the stored word, with no memory request.
- R5: A write hit updates the stored word and marks the line dirty, with no memory request. A later read returns the new word.
- R6: A write miss reads the line from memory, merges the write data into the cache, reports `cpu_miss`=1, and writes nothing to memory.
- R7: On a miss, an invalid way in the set is filled before any valid way is evicted (way 0 is checked first).
- R8: When both ways are valid, the way named by the set's replacement bit is evicted. Every hit, and every fill, sets that bit to the other way.
- R9: A dirty victim is written to memory at its own address with its own data before the refill read is issued.
- R10: A refilled line is clean, so evicting it later causes no memory write.
- R11: Once raised, `mem_req` stays high with a stable address, direction and data until `mem_ack`.
- R12: `cpu_ready` is a single-cycle pulse. In that cycle exactly one of `cpu_hit` and `cpu_miss` is high, and neither is high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with ready |
| cpu_hit | output | 1 | Access served without a fill |
| cpu_miss | output | 1 | Access needed a fill |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Word address to memory |
| mem_wdata | output | 32 | Victim data for write-back |
| mem_ack | input | 1 | Memory acknowledge pulse |
| mem_rdata | input | 32 | Refill data, valid with acknowledge |

## Verification
A wrong replacement bit only shows at the ports a few accesses later: an address that should have stayed resident misses, or the wrong victim is evicted. The bench therefore touches ways in a planned order and then checks which address survives. A stuck or missing dirty bit shows up when that line is evicted: either a write-back is missing, or a spurious write-back appears, or memory receives the wrong address or data. Each of these is counted at the memory port during the eviction access. State that is not cleared by reset appears on the very next access, as a hit where a miss is expected.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FLUSH,
        ST_FILL
    } cc_state_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  cmp_tag,
    output logic              hit,
    output logic              vld,
    output logic              dirty,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] data,
    input  logic              wr_en,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            vld_q[idx]   <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_data;
        end
    end

    assign vld   = vld_q[idx];
    assign dirty = dirty_q[idx];
    assign tag   = tag_q[idx];
    assign data  = data_q[idx];
    assign hit   = vld && (tag == cmp_tag);
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             req_we,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       way_hit,
    input  logic [1:0]       way_vld,
    input  logic [1:0]       way_dirty,
    input  logic             mem_ack,
    output logic             accept,
    output logic             ready,
    output logic             miss_seen,
    output logic [1:0]       way_wr,
    output logic             wr_fill,
    output logic             victim,
    output logic             mem_req,
    output logic             mem_we
);
    cc_state_e       state_q, state_d;
    logic [SETS-1:0] lru_q;
    logic            vict_q;
    logic            miss_q;
    logic            pick;
    logic            any_hit;

    assign any_hit = |way_hit;
    assign pick    = !way_vld[0] ? 1'b0 :
                     !way_vld[1] ? 1'b1 : lru_q[idx];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (any_hit)                                 state_d = ST_IDLE;
                else if (way_vld[pick] && way_dirty[pick])   state_d = ST_FLUSH;
                else                                         state_d = ST_FILL;
            end
            ST_FLUSH:  if (mem_ack) state_d = ST_FILL;
            ST_FILL:   if (mem_ack) state_d = ST_LOOKUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lru_q   <= '0;
            vict_q  <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) miss_q <= 1'b0;
            if (state_q == ST_LOOKUP && !any_hit) begin
                miss_q <= 1'b1;
                vict_q <= pick;
            end
            if (state_q == ST_LOOKUP && any_hit) lru_q[idx] <= way_hit[0];
            if (state_q == ST_FILL && mem_ack)   lru_q[idx] <= ~vict_q;
        end
    end

    always_comb begin
        accept  = 1'b0;
        ready   = 1'b0;
        way_wr  = 2'b00;
        wr_fill = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = cpu_req;
            ST_LOOKUP: begin
                ready = any_hit;
                if (req_we) way_wr = way_hit;
            end
            ST_FLUSH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                wr_fill = 1'b1;
                if (mem_ack) way_wr = vict_q ? 2'b10 : 2'b01;
            end
            default: ;
        endcase
    end

    assign victim    = vict_q;
    assign miss_seen = miss_q;
endmodule

// File: rtl/cache2w.sv
module cache2w #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 4,
    localparam int OFF_W = $clog2(DATA_W / 8),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_miss,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              unused_off;

    logic [1:0]        way_hit, way_vld, way_dirty, way_wr;
    logic [TAG_W-1:0]  way_tag  [2];
    logic [DATA_W-1:0] way_data [2];
    logic              accept, ready, miss_seen, wr_fill, victim;
    logic [DATA_W-1:0] wr_word;

    assign unused_off = ^cpu_addr[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            idx_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            tag_q   <= cpu_addr[ADDR_W-1:OFF_W+IDX_W];
            idx_q   <= cpu_addr[OFF_W+IDX_W-1:OFF_W];
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
        end
    end

    assign wr_word = wr_fill ? mem_rdata : wdata_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        cache2w_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (idx_q),
            .cmp_tag  (tag_q),
            .hit      (way_hit[w]),
            .vld      (way_vld[w]),
            .dirty    (way_dirty[w]),
            .tag      (way_tag[w]),
            .data     (way_data[w]),
            .wr_en    (way_wr[w]),
            .wr_dirty (!wr_fill),
            .wr_tag   (tag_q),
            .wr_data  (wr_word)
        );
    end

    cache2w_ctrl #(.SETS(SETS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .req_we    (we_q),
        .idx       (idx_q),
        .way_hit   (way_hit),
        .way_vld   (way_vld),
        .way_dirty (way_dirty),
        .mem_ack   (mem_ack),
        .accept    (accept),
        .ready     (ready),
        .miss_seen (miss_seen),
        .way_wr    (way_wr),
        .wr_fill   (wr_fill),
        .victim    (victim),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    assign cpu_ready = ready;
    assign cpu_hit   = ready && !miss_seen;
    assign cpu_miss  = ready && miss_seen;
    assign cpu_rdata = way_hit[1] ? way_data[1] : way_data[0];
    assign mem_wdata = way_data[victim];
    assign mem_addr  = {(mem_we ? way_tag[victim] : tag_q), idx_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic              cpu_miss,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    flush_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R12
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({cpu_hit, cpu_miss}) == (cpu_ready ? 1 : 0)));

    // R4
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);
endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_hit   (cpu_hit),
    .cpu_miss  (cpu_miss),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/cache2w_bench.sv
module cache2w_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_hit, cpu_miss;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, failures = 0, cycles = 0;
    bit timed_out = 0;

    logic [31:0] mem_arr [64];
    logic [63:0] mem_set = '0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] last_wa = '0, last_wd = '0;
    logic [1:0]  op_hist = '0;

    cache2w u_cache2w (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return (a * 32'd7) ^ 32'h3C3C_0000;
    endfunction

    // Backing memory: acknowledges each request one cycle after it is seen.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            op_hist <= {op_hist[0], mem_we};
            if (mem_we) begin
                mem_arr[mem_addr[7:2]] <= mem_wdata;
                mem_set[mem_addr[7:2]] <= 1'b1;
                n_wr    <= n_wr + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end else begin
                mem_rdata <= mem_set[mem_addr[7:2]] ? mem_arr[mem_addr[7:2]] : dflt(mem_addr);
                n_rd      <= n_rd + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !timed_out) begin
            timed_out = 1;
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output bit hit, output bit miss,
                          output int drd, output int dwr);
        int rd0, wr0;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ready);
        rd = cpu_rdata; hit = cpu_hit; miss = cpu_miss;
        drd = n_rd - rd0; dwr = n_wr - wr0;
        cpu_req = 1'b0;
        // R12: exactly one status flag with ready, and ready lasts one cycle
        chk(hit ^ miss, "R12 status", {30'd0, hit, miss}, 32'h1);
        @(negedge clk);
        chk(!cpu_ready, "R12 pulse", {31'd0, cpu_ready}, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [31:0] rd;
    bit h, m;
    int dr, dw;

    task automatic t_reset();
        do_reset();
        chk(!cpu_ready && !mem_req, "R1 idle outputs", {30'd0, cpu_ready, mem_req}, 32'h0);
    endtask

    task automatic t_cold_read();
        access(0, 32'h0, 0, rd, h, m, dr, dw);
        chk(m, "R1 cold miss", {31'd0, m}, 32'h1);
        chk(rd == dflt(0), "R3 refill data", rd, dflt(0));
        chk(dr == 1 && dw == 0, "R3 one read", dr * 16 + dw, 32'h10);
    endtask

    task automatic t_hits();
        access(0, 32'h0, 0, rd, h, m, dr, dw);
        chk(h && rd == dflt(0), "R4 read hit", rd, dflt(0));
        chk(dr == 0 && dw == 0, "R4 no traffic", dr * 16 + dw, 32'h0);
        access(1, 32'h2, 32'hDEAD_BEEF, rd, h, m, dr, dw);   // R2: offset bits ignored
        chk(h && dr == 0 && dw == 0, "R5 write hit quiet", {h, 7'd0, dr[11:0], dw[11:0]}, 32'h8000_0000);
        access(0, 32'h0, 0, rd, h, m, dr, dw);
        chk(h && rd == 32'hDEAD_BEEF, "R5 new word", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_fill_invalid();
        access(0, 32'h10, 0, rd, h, m, dr, dw);
        chk(m && dw == 0 && dr == 1, "R7 invalid way filled", dw, 0);
        access(0, 32'h0, 0, rd, h, m, dr, dw);
        chk(h && rd == 32'hDEAD_BEEF, "R2 both tags resident", rd, 32'hDEAD_BEEF);
        access(0, 32'h10, 0, rd, h, m, dr, dw);
        chk(h && rd == dflt(32'h10), "R2 second tag hit", rd, dflt(32'h10));
    endtask

    task automatic t_dirty_evict();
        access(0, 32'h20, 0, rd, h, m, dr, dw);
        chk(m && dw == 1 && dr == 1, "R9 write-back then refill", dw, 1);
        chk(last_wa == 32'h0 && last_wd == 32'hDEAD_BEEF, "R9 victim addr/data", last_wd, 32'hDEAD_BEEF);
        chk(op_hist == 2'b10, "R9 write before read", {30'd0, op_hist}, 32'h2);   // R11 order on port
        chk(rd == dflt(32'h20), "R3 refill after flush", rd, dflt(32'h20));
        access(0, 32'h10, 0, rd, h, m, dr, dw);
        chk(h, "R8 recent way kept", {31'd0, h}, 32'h1);
    endtask

    task automatic t_lru();
        access(0, 32'h30, 0, rd, h, m, dr, dw);
        chk(m && dw == 0, "R10 clean victim no write", dw, 0);
        chk(rd == dflt(32'h30), "R8 refill data", rd, dflt(32'h30));
        access(0, 32'h10, 0, rd, h, m, dr, dw);
        chk(h, "R8 lru kept 0x10", {31'd0, h}, 32'h1);
        access(0, 32'h20, 0, rd, h, m, dr, dw);
        chk(m && dw == 0, "R8 lru evicted 0x20", {31'd0, m}, 32'h1);
        access(0, 32'h30, 0, rd, h, m, dr, dw);
        chk(m, "R8 0x30 now evicted", {31'd0, m}, 32'h1);
    endtask

    task automatic t_write_miss();
        access(1, 32'h4, 32'h1234_5678, rd, h, m, dr, dw);
        chk(m && dr == 1 && dw == 0, "R6 allocate no write", dw, 0);
        access(0, 32'h4, 0, rd, h, m, dr, dw);
        chk(h && rd == 32'h1234_5678, "R6 merged word", rd, 32'h1234_5678);
    endtask

    task automatic t_reset_clears();
        do_reset();
        access(0, 32'h4, 0, rd, h, m, dr, dw);
        chk(m && dw == 0, "R1 valid and dirty cleared", dw, 0);
        chk(rd == dflt(32'h4), "R1 memory untouched", rd, dflt(32'h4));
    endtask

    initial begin
        t_reset();
        t_cold_read();
        t_hits();
        t_fill_invalid();
        t_dirty_evict();
        t_lru();
        t_write_miss();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule